// File: doc/BRIEF.md
# Configurable Memory Map Decoder

This block sits between the address generator of an 8-bit microcontroller core and the rest of the memory system. For each access it decides where the access goes. The access carries an address of up to 23 bits and a kind: idle, program fetch, data read or data write. There are four possible targets. The first is the 4 kB on-chip SRAM. The second is the message area of the CAN controller. The third is a reserved stack region, which no user target serves. The fourth is the external bus. For an external access the block drives the active-low read, write and program-store strobes and the chip-select lines. It also routes each of the eight port pins either to its memory function or to the value in the port output register.

A small configuration register holds five fields. A 2-bit window mode places the SRAM and CAN windows. A stack-reservation flag removes part of the SRAM window from user data access. A 3-bit address-line code sets how many upper address lines appear on port pins 7–4. A 3-bit chip-select code sets how many chip selects appear on port pins 3–0. The register loads on a write strobe. Every decode output is combinational from the access inputs and the registered configuration.

Top module: `memmap_decoder`

## Requirements
- R1: After a synchronous reset the configuration holds mode 00, reservation off and both pin codes 111. As a result all eight pins carry memory functions (`port_is_mem` = FFh), and a fetch from address 0 gives `ext_psen_n`=0 with only chip select 0 low (`port_out[3:0]`=1110b).
- R2: A read or write inside the SRAM window sets `hit_sram`. The window lies at 00F000h–00FFFFh in mode 00, at 000000h–000FFFh in mode 01, and at 400000h–400FFFh in modes 10 and 11.
- R3: In mode 11 a program fetch inside 400000h–400FFFh also sets `hit_sram`. In modes 00, 01 and 10, a fetch that falls in the SRAM window goes to the external bus.
- R4: A read or write inside the CAN window sets `hit_can`. The window is 00EE00h–00EFFFh in modes 00 and 01, and 401000h–4011FFh in modes 10 and 11. A fetch there never sets `hit_can`. The CAN window takes precedence over the SRAM window and the SRAM window over the external bus.
- R5: With the reservation flag set and a mode other than 11, a read or write in the lowest 1 kB of the SRAM window sets `hit_rsv` and neither `hit_sram` nor `hit_ext`. In mode 11 the flag has no effect.
- R6: `hit_ext` is set for a non-idle access that hits no internal window. Only then is exactly one strobe low: `ext_psen_n` for a fetch, `ext_rd_n` for a read, `ext_wr_n` for a write. Idle and internal accesses leave all strobes high.
- R7: The address-line code enables pins 4..4+n-1 as address lines A16..A16+n-1 (`port_is_mem`=1, `port_out` = the address bit). The code 111 gives n=4, 110 gives 3, 101 gives 2 and 100 gives 1.
- R8: The chip-select code enables pins 0..m-1 as chip selects (`port_is_mem`=1). The code 111 gives m=4, 110 gives 3, 101 gives 2 and 100 gives 1.
- R9: Chip select j (active low, on pin j) is low only during an external access whose address bits [15+n:14+n] equal j, with j < m. Each select thus covers one quarter of a range of 2^(16+n) bytes.
- R10: Every pin not enabled by its code outputs the matching bit of `port_latch` and reports `port_is_mem`=0. The codes 000, 001, 010 and 011 all enable no pins.
- R11: The configuration changes only on a clock edge with `cfg_wr`=1 and outside reset. An access in the same cycle as that write is decoded with the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Load the configuration fields on this edge |
| cfg_win_mode | input | 2 | New window mode |
| cfg_stack_rsv | input | 1 | New stack-reservation flag |
| cfg_aline_code | input | 3 | New address-line pin code |
| cfg_csel_code | input | 3 | New chip-select pin code |
| acc_kind | input | 2 | 00 idle, 01 fetch, 10 read, 11 write |
| acc_addr | input | ADDR_W | Access address |
| port_latch | input | 8 | Port output register value for I/O pins |
| hit_sram | output | 1 | Access served by on-chip SRAM |
| hit_can | output | 1 | Access served by CAN message area |
| hit_rsv | output | 1 | Access falls in the reserved stack region |
| hit_ext | output | 1 | Access goes to the external bus |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| ext_psen_n | output | 1 | External program-store strobe, active low |
| port_out | output | 8 | Pin values: address, chip selects or latch |
| port_is_mem | output | 8 | Per pin, 1 when the pin carries a memory function |

## Verification
Two things can fall in the same cycle. A configuration write can coincide with an access, and one address can lie in both the SRAM window and the reserved stack region. The bench provokes the first by issuing writes during active accesses in a long mixed run. It judges the result against a model that applies the new configuration only after the edge. It provokes the second by sweeping the edges of the window and of the reserved 1 kB region in every mode, with the flag both set and cleared, for every access kind. The bench expects the reserved region to win except in mode 11.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_FETCH = 2'b01,
        ACC_READ  = 2'b10,
        ACC_WRITE = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic [1:0] win_mode;
        logic       stack_rsv;
        logic [2:0] aline_code;
        logic [2:0] csel_code;
    } map_cfg_t;

    localparam map_cfg_t CFG_RESET = '{win_mode: 2'b00, stack_rsv: 1'b0,
                                       aline_code: 3'b111, csel_code: 3'b111};

    localparam int PIN_GROUP = 4;

    localparam logic [31:0] SRAM_BASE_TOP   = 32'h0000_F000;
    localparam logic [31:0] SRAM_BASE_ZERO  = 32'h0000_0000;
    localparam logic [31:0] SRAM_BASE_HIGH  = 32'h0040_0000;
    localparam logic [31:0] CAN_BASE_LOW    = 32'h0000_EE00;
    localparam logic [31:0] CAN_BASE_HIGH   = 32'h0040_1000;

    function automatic logic [2:0] code_to_count(input logic [2:0] code);
        case (code)
            3'b111:  return 3'd4;
            3'b110:  return 3'd3;
            3'b101:  return 3'd2;
            3'b100:  return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/memmap_cfg_regs.sv
module memmap_cfg_regs
    import memmap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  map_cfg_t cfg_in,
    output map_cfg_t cfg_q
);

    typedef struct packed {
        map_cfg_t cfg;
    } state_t;

    state_t state_d;
    state_t state_q;

    always_comb begin
        state_d = state_q;
        if (wr) begin
            state_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.cfg <= CFG_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_q = state_q.cfg;

endmodule

// File: rtl/memmap_region.sv
module memmap_region
    import memmap_pkg::*;
#(
    parameter int ADDR_W   = 23,
    parameter int SRAM_LG  = 12,
    parameter int STACK_LG = 10,
    parameter int CAN_LG   = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_kind_e         kind,
    input  logic [1:0]        win_mode,
    input  logic              stack_rsv,
    output logic              hit_sram,
    output logic              hit_can,
    output logic              hit_rsv,
    output logic              hit_ext,
    output logic              rd_n,
    output logic              wr_n,
    output logic              psen_n
);

    function automatic logic in_win(input logic [31:0] a, input logic [31:0] base, input int lg);
        return (a >> lg) == (base >> lg);
    endfunction

    typedef struct packed {
        logic sram;
        logic can;
        logic rsv;
        logic ext;
    } route_t;

    logic [31:0] addr_w;
    logic [31:0] sram_base;
    logic [31:0] can_base;
    logic        is_data;
    logic        is_fetch;
    logic        in_sram;
    logic        shared_mode;
    route_t      route_d;

    always_comb begin
        addr_w      = 32'(addr);
        is_data     = (kind == ACC_READ) || (kind == ACC_WRITE);
        is_fetch    = (kind == ACC_FETCH);
        shared_mode = (win_mode == 2'b11);

        case (win_mode)
            2'b00:   sram_base = SRAM_BASE_TOP;
            2'b01:   sram_base = SRAM_BASE_ZERO;
            default: sram_base = SRAM_BASE_HIGH;
        endcase
        can_base = win_mode[1] ? CAN_BASE_HIGH : CAN_BASE_LOW;

        in_sram = in_win(addr_w, sram_base, SRAM_LG);

        route_d.can  = is_data && in_win(addr_w, can_base, CAN_LG);
        route_d.rsv  = !route_d.can && is_data && in_sram && stack_rsv &&
                       !shared_mode && in_win(addr_w, sram_base, STACK_LG);
        route_d.sram = !route_d.can && !route_d.rsv && in_sram &&
                       (is_data || (is_fetch && shared_mode));
        route_d.ext  = (kind != ACC_IDLE) && !route_d.can && !route_d.rsv && !route_d.sram;
    end

    assign hit_sram = route_d.sram;
    assign hit_can  = route_d.can;
    assign hit_rsv  = route_d.rsv;
    assign hit_ext  = route_d.ext;
    assign rd_n     = !(route_d.ext && kind == ACC_READ);
    assign wr_n     = !(route_d.ext && kind == ACC_WRITE);
    assign psen_n   = !(route_d.ext && kind == ACC_FETCH);

endmodule

// File: rtl/memmap_pins.sv
module memmap_pins
    import memmap_pkg::*;
#(
    parameter int PINS = PIN_GROUP,
    localparam int SLICE_W = PINS + 2,
    localparam int PORT_W  = 2 * PINS
) (
    input  logic [SLICE_W-1:0] addr_slice,
    input  logic               ext_access,
    input  logic [2:0]         aline_code,
    input  logic [2:0]         csel_code,
    input  logic [PORT_W-1:0]  port_latch,
    output logic [PORT_W-1:0]  port_out,
    output logic [PORT_W-1:0]  port_is_mem,
    output logic [PINS-1:0]    csel_n
);

    logic [2:0] n_lines;
    logic [2:0] n_csel;
    logic [1:0] quarter;

    always_comb begin
        n_lines = code_to_count(aline_code);
        n_csel  = code_to_count(csel_code);
        quarter = addr_slice[int'(n_lines) +: 2];
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic aline_en;
        logic csel_en;

        assign aline_en = (3'(i) < n_lines);
        assign csel_en  = (3'(i) < n_csel);

        assign port_is_mem[PINS+i] = aline_en;
        assign port_out[PINS+i]    = aline_en ? addr_slice[2+i] : port_latch[PINS+i];

        assign csel_n[i]      = !(csel_en && ext_access && quarter == 2'(i));
        assign port_is_mem[i] = csel_en;
        assign port_out[i]    = csel_en ? csel_n[i] : port_latch[i];
    end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int SRAM_LG   = 12,
    parameter int STACK_LG  = 10,
    parameter int CAN_LG    = 9,
    parameter int ALINE_LSB = 16,
    localparam int PORT_W   = 2 * PIN_GROUP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_win_mode,
    input  logic              cfg_stack_rsv,
    input  logic [2:0]        cfg_aline_code,
    input  logic [2:0]        cfg_csel_code,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PORT_W-1:0] port_latch,
    output logic              hit_sram,
    output logic              hit_can,
    output logic              hit_rsv,
    output logic              hit_ext,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_psen_n,
    output logic [PORT_W-1:0] port_out,
    output logic [PORT_W-1:0] port_is_mem
);

    map_cfg_t               cfg_in;
    map_cfg_t               cfg_q;
    logic [PIN_GROUP-1:0]   csel_n;

    assign cfg_in = '{win_mode: cfg_win_mode, stack_rsv: cfg_stack_rsv,
                      aline_code: cfg_aline_code, csel_code: cfg_csel_code};

    memmap_cfg_regs i_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    memmap_region #(
        .ADDR_W   (ADDR_W),
        .SRAM_LG  (SRAM_LG),
        .STACK_LG (STACK_LG),
        .CAN_LG   (CAN_LG)
    ) i_region (
        .addr      (acc_addr),
        .kind      (acc_kind_e'(acc_kind)),
        .win_mode  (cfg_q.win_mode),
        .stack_rsv (cfg_q.stack_rsv),
        .hit_sram  (hit_sram),
        .hit_can   (hit_can),
        .hit_rsv   (hit_rsv),
        .hit_ext   (hit_ext),
        .rd_n      (ext_rd_n),
        .wr_n      (ext_wr_n),
        .psen_n    (ext_psen_n)
    );

    memmap_pins #(
        .PINS (PIN_GROUP)
    ) i_pins (
        .addr_slice  (acc_addr[ALINE_LSB+PIN_GROUP-1:ALINE_LSB-2]),
        .ext_access  (hit_ext),
        .aline_code  (cfg_q.aline_code),
        .csel_code   (cfg_q.csel_code),
        .port_latch  (port_latch),
        .port_out    (port_out),
        .port_is_mem (port_is_mem),
        .csel_n      (csel_n)
    );

endmodule

// File: rtl/memmap_checker.sv
module memmap_checker
    import memmap_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input map_cfg_t   cfg_in,
    input map_cfg_t   cfg_q,
    input logic [1:0] acc_kind,
    input logic       hit_sram,
    input logic       hit_can,
    input logic       hit_rsv,
    input logic       hit_ext,
    input logic       ext_rd_n,
    input logic       ext_wr_n,
    input logic       ext_psen_n,
    input logic [3:0] csel_n
);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_sram, hit_can, hit_rsv, hit_ext}));                               // R4

    AST_INTERNAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (hit_sram || hit_can || hit_rsv) |-> (ext_rd_n && ext_wr_n && ext_psen_n));     // R2

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!ext_rd_n, !ext_wr_n, !ext_psen_n}));                                  // R6

    AST_READ_STROBE_KIND: assert property (@(posedge clk) disable iff (rst)
        !ext_rd_n |-> (acc_kind == 2'b10));                                              // R6

    AST_CSEL_ONLY_EXT: assert property (@(posedge clk) disable iff (rst)
        (csel_n != 4'hF) |-> (hit_ext && $countones(~csel_n) == 1));                     // R9

    AST_SHARED_NO_RSV: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.win_mode == 2'b11) |-> !hit_rsv);                                         // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(cfg_q));                                                     // R11

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_q == $past(cfg_in)));                                            // R11

endmodule

bind memmap_decoder memmap_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_in     (cfg_in),
    .cfg_q      (cfg_q),
    .acc_kind   (acc_kind),
    .hit_sram   (hit_sram),
    .hit_can    (hit_can),
    .hit_rsv    (hit_rsv),
    .hit_ext    (hit_ext),
    .ext_rd_n   (ext_rd_n),
    .ext_wr_n   (ext_wr_n),
    .ext_psen_n (ext_psen_n),
    .csel_n     (csel_n)
);

// File: tb/test_memmap_decoder.sv
`timescale 1ns/1ps
module test_memmap_decoder;
    import memmap_pkg::*;

    localparam int ADDR_W = 23;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst;
    logic              cfg_wr;
    logic [1:0]        cfg_win_mode;
    logic              cfg_stack_rsv;
    logic [2:0]        cfg_aline_code;
    logic [2:0]        cfg_csel_code;
    logic [1:0]        acc_kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [7:0]        port_latch;
    logic              hit_sram, hit_can, hit_rsv, hit_ext;
    logic              ext_rd_n, ext_wr_n, ext_psen_n;
    logic [7:0]        port_out, port_is_mem;

    memmap_decoder i_memmap_decoder (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_win_mode(cfg_win_mode),
        .cfg_stack_rsv(cfg_stack_rsv), .cfg_aline_code(cfg_aline_code),
        .cfg_csel_code(cfg_csel_code), .acc_kind(acc_kind), .acc_addr(acc_addr),
        .port_latch(port_latch), .hit_sram(hit_sram), .hit_can(hit_can),
        .hit_rsv(hit_rsv), .hit_ext(hit_ext), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_psen_n(ext_psen_n), .port_out(port_out),
        .port_is_mem(port_is_mem)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference configuration, updated only after a write edge
    int m_mode = 0;
    int m_stk  = 0;
    int m_ac   = 7;
    int m_cc   = 7;

    task automatic chk(input string tag, input string ctx, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] addr=%h kind=%0d actual=%h expected=%h",
                     tag, ctx, acc_addr, acc_kind, act, exp);
        end
    endtask

    function automatic int lines_of(input int code);
        if (code == 7) return 4;
        if (code == 6) return 3;
        if (code == 5) return 2;
        if (code == 4) return 1;
        return 0;
    endfunction

    task automatic compare(input string ctx);
        int a, sb, cb, k, n, m, q;
        bit dat, fet, e_can, ins, e_rsv, e_sram, e_ext;
        logic [7:0] e_out, e_mem;
        a = int'(acc_addr);
        k = int'(acc_kind);
        sb = (m_mode == 0) ? 'hF000 : (m_mode == 1) ? 0 : 'h400000;
        cb = (m_mode < 2) ? 'hEE00 : 'h401000;
        dat = (k == 2) || (k == 3);
        fet = (k == 1);
        e_can  = dat && a >= cb && a < cb + 512;
        ins    = a >= sb && a < sb + 4096;
        e_rsv  = !e_can && dat && ins && m_stk == 1 && m_mode != 3 && a < sb + 1024;
        e_sram = !e_can && !e_rsv && ins && (dat || (fet && m_mode == 3));
        e_ext  = k != 0 && !e_can && !e_rsv && !e_sram;
        n = lines_of(m_ac);
        m = lines_of(m_cc);
        q = (a >> (14 + n)) & 3;
        for (int i = 0; i < 4; i++) begin
            e_mem[4+i] = (i < n);
            e_out[4+i] = (i < n) ? acc_addr[16+i] : port_latch[4+i];
            e_mem[i]   = (i < m);
            e_out[i]   = (i < m) ? !(e_ext && q == i) : port_latch[i];
        end
        chk("R2/R3 hit_sram", ctx, 32'(hit_sram), 32'(e_sram));
        chk("R4 hit_can",     ctx, 32'(hit_can),  32'(e_can));
        chk("R5 hit_rsv",     ctx, 32'(hit_rsv),  32'(e_rsv));
        chk("R6 hit_ext",     ctx, 32'(hit_ext),  32'(e_ext));
        chk("R6 strobes",     ctx, {29'd0, ext_rd_n, ext_wr_n, ext_psen_n},
            {29'd0, !(e_ext && k == 2), !(e_ext && k == 3), !(e_ext && k == 1)});
        chk("R7 addr pin function", ctx, 32'(port_is_mem[7:4]), 32'(e_mem[7:4]));
        chk("R8 csel pin function", ctx, 32'(port_is_mem[3:0]), 32'(e_mem[3:0]));
        chk("R9 csel pins",   ctx, 32'(port_out[3:0]), 32'(e_out[3:0]));
        chk("R10 addr pins",  ctx, 32'(port_out[7:4]), 32'(e_out[7:4]));
    endtask

    task automatic step(input bit wr, input int mode, input int stk, input int ac, input int cc,
                        input int kind, input int addr, input string ctx);
        @(negedge clk);
        cfg_wr         = wr;
        cfg_win_mode   = 2'(mode);
        cfg_stack_rsv  = 1'(stk);
        cfg_aline_code = 3'(ac);
        cfg_csel_code  = 3'(cc);
        acc_kind       = 2'(kind);
        acc_addr       = ADDR_W'(addr);
        port_latch     = 8'($urandom);
        #1;
        compare(ctx);
        @(posedge clk);
        if (wr && !rst) begin
            m_mode = mode; m_stk = stk; m_ac = ac; m_cc = cc;
        end
    endtask

    initial begin
        #(100000 * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int pts[9];
        rst = 1'b1; cfg_wr = 1'b0; cfg_win_mode = 2'd1; cfg_stack_rsv = 1'b1;
        cfg_aline_code = 3'd0; cfg_csel_code = 3'd0; acc_kind = 2'd0;
        acc_addr = '0; port_latch = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, first fetch from address 0
        step(0, 1, 1, 0, 0, 1, 0, "R1 reset fetch");
        chk("R1 psen", "reset", 32'(ext_psen_n), 32'd0);
        chk("R1 csel", "reset", 32'(port_out[3:0]), 32'hE);
        chk("R1 pins", "reset", 32'(port_is_mem), 32'hFF);

        // window edges in every mode, reservation off and on, every kind
        for (int md = 0; md < 4; md++) begin
            for (int sk = 0; sk < 2; sk++) begin
                int sb, cb;
                sb = (md == 0) ? 'hF000 : (md == 1) ? 0 : 'h400000;
                cb = (md < 2) ? 'hEE00 : 'h401000;
                pts = '{sb, sb + 1023, sb + 1024, sb + 4095, sb + 4096,
                        (sb == 0) ? 'h3FFFFF : sb - 1, cb, cb + 511, cb + 512};
                step(1, md, sk, 7, 7, 0, 0, "R11 cfg write");
                foreach (pts[p]) begin
                    for (int k = 0; k < 4; k++) begin
                        step(0, 0, 0, 0, 0, k, pts[p], "R2 R3 R4 R5 window edges");
                    end
                end
            end
        end

        // every pin code pair, reserved codes included
        for (int ac = 0; ac < 8; ac++) begin
            for (int cc = 0; cc < 8; cc++) begin
                step(1, 0, 0, ac, cc, 0, 0, "R7 R8 code write");
                step(0, 0, 0, 0, 0, 1, 'h00000,  "R9 R10 sweep");
                step(0, 0, 0, 0, 0, 2, 'h4C123,  "R9 R10 sweep");
                step(0, 0, 0, 0, 0, 3, 'h93000,  "R9 R10 sweep");
                step(0, 0, 0, 0, 0, 1, 'hE7000,  "R9 R10 sweep");
                step(0, 0, 0, 0, 0, 2, 'h3FFFFF, "R9 R10 sweep");
            end
        end

        // R11: configuration inputs move without a write strobe
        step(1, 0, 1, 6, 5, 0, 0, "R11 set");
        for (int i = 0; i < 40; i++) begin
            step(0, 3 - (i % 4), i % 2, i % 8, (i + 3) % 8, 1 + (i % 3),
                 (i % 2) ? 'hF000 + i * 37 : 'h400000 + i * 101, "R11 hold");
        end

        // mixed run, writes landing in the same cycle as accesses
        for (int i = 0; i < 3000; i++) begin
            int bases[6];
            int a;
            bases = '{'hF000, 0, 'h400000, 'hEE00, 'h401000, 'hA0000};
            a = bases[$urandom_range(0, 5)] + $urandom_range(0, 5000);
            if ($urandom_range(0, 7) == 0) a = int'($urandom_range(0, 'h7FFFFF));
            step($urandom_range(0, 15) == 0, $urandom_range(0, 3), $urandom_range(0, 1),
                 $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 3), a,
                 "R11 mixed");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule